// File: doc/BRIEF.md
# Lane-Partitioned SIMD Adder/Subtractor

This block is a 48-bit add/subtract datapath that can be split into narrower, independent lanes. The first operand is built by placing a 30-bit upper input above an 18-bit lower input. The second operand is a 48-bit input. A mode input selects one of three layouts: one 48-bit lane, two 24-bit lanes, or four 12-bit lanes. A single operation bit applies to every lane at once. Each lane either adds the joined operand to the second operand, or subtracts the joined operand from the second operand.

Carries never cross a lane boundary. Each lane reports its carry-out in a shared 4-bit carry vector. The positions of those bits depend on the layout. The result and the carry vector can leave through an optional output register with a clock enable and a synchronous clear. The register is selected by a parameter; without it, the outputs are combinational. The block is intended to pack several short adders or subtractors that share one control into a single wide datapath.

Top module: `simd_addsub`

## Requirements
- R1: The joined operand is {opa_hi_i, opa_lo_i}, with opa_hi_i in bits 47..18 and opa_lo_i in bits 17..0. When sub_i=0, each lane's result is that lane's slice of the joined operand plus the same slice of opc_i, modulo the lane width.
- R2: When sub_i=1, each lane's result is the lane slice of opc_i minus the lane slice of the joined operand, modulo the lane width.
- R3: mode_i=2'b10 forms four 12-bit lanes at bits 11..0, 23..12, 35..24 and 47..36. No carry or borrow passes between them.
- R4: mode_i=2'b01 forms two 24-bit lanes at bits 23..0 and 47..24. No carry or borrow passes between them.
- R5: mode_i=2'b00 and mode_i=2'b11 both form a single 48-bit lane.
- R6: In the four-lane layout, carry_o[i] is the carry-out of lane i.
- R7: In the two-lane layout, carry_o[1] holds the lower lane's carry and carry_o[3] holds the upper lane's carry. carry_o[0] and carry_o[2] are 0.
- R8: In the single-lane layout, carry_o[3] is the carry out of bit 47 and carry_o[2:0] are 0.
- R9: In subtraction, a lane's carry bit is 1 when no borrow occurred (C slice >= operand slice) and 0 when a borrow occurred.
- R10: With OUT_REG=1, the result and carry for inputs present at a rising clock edge where ce=1 and sclr=0 appear on the outputs after that edge.
- R11: With OUT_REG=1, an edge with ce=0 and sclr=0 leaves result_o and carry_o unchanged, whatever the data inputs do.
- R12: An edge with sclr=1 clears result_o and carry_o to zero, whether or not ce is set. A low rst_n clears them at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| ce | input | 1 | Output register load enable |
| sclr | input | 1 | Synchronous clear of the output register |
| mode_i | input | 2 | Lane layout: 00/11 one lane, 01 two lanes, 10 four lanes |
| sub_i | input | 1 | 0 = add in every lane, 1 = subtract in every lane |
| opa_hi_i | input | 30 | Upper part of the joined operand (bits 47..18) |
| opa_lo_i | input | 18 | Lower part of the joined operand (bits 17..0) |
| opc_i | input | 48 | Second operand |
| result_o | output | 48 | Packed lane results |
| carry_o | output | 4 | Per-lane carry vector |

## Verification
On every cycle, the assertions check the following:
- which carry bits are zero in the two-lane and single-lane layouts;
- the arithmetic of the lowest 12-bit lane against a reference sum computed independently;
- the load, hold and clear behaviour of the output register.

Only the bench scenarios can show that carries are cut at the upper lane boundaries. They do this with all-ones operands whose carries would otherwise ripple across. The same applies to the borrow sense of the carry bits in the upper lanes, and to the equivalence of mode codes 00 and 11. An asynchronous reset in the middle of a run is also checked only by the bench.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int WORD_W  = 48;
  localparam int HI_W    = 30;
  localparam int LO_W    = 18;
  localparam int SLICE_W = 12;
  localparam int N_SLICE = WORD_W / SLICE_W;

  typedef enum logic [1:0] {
    LM_FULL    = 2'b00,
    LM_HALF    = 2'b01,
    LM_QUARTER = 2'b10,
    LM_FULL_B  = 2'b11
  } lane_mode_e;
endpackage

// File: rtl/simd_slice.sv
module simd_slice #(
  parameter int W = 12
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] s_o,
  output logic         cout_o
);
  logic [W:0] ext;

  // y + (x or ~x) + cin; subtraction is y - x via two's complement
  always_comb begin
    ext    = {1'b0, y_i} + {1'b0, x_i ^ {W{sub_i}}} + {{W{1'b0}}, cin_i};
    s_o    = ext[W-1:0];
    cout_o = ext[W];
  end
endmodule

// File: rtl/simd_lane_ctrl.sv
module simd_lane_ctrl
  import simd_pkg::*;
#(
  parameter int N = 4
) (
  input  lane_mode_e   mode_i,
  output logic [N-1:0] start_o,
  output logic [N-1:0] end_o
);
  localparam int HALF = N / 2;

  logic quarter, half;
  assign quarter = (mode_i == LM_QUARTER);
  assign half    = (mode_i == LM_HALF);

  for (genvar k = 0; k < N; k++) begin : g_bnd
    assign start_o[k] = (k == 0)     | quarter | (half & (k == HALF));
    assign end_o[k]   = (k == N - 1) | quarter | (half & (k == HALF - 1));
  end
endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
  parameter int W       = 48,
  parameter int CW      = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          sclr,
  input  logic [W-1:0]  d_sum,
  input  logic [CW-1:0] d_cy,
  output logic [W-1:0]  q_sum,
  output logic [CW-1:0] q_cy
);
  if (OUT_REG) begin : g_reg
    logic [W-1:0]  sum_q, sum_nx;
    logic [CW-1:0] cy_q, cy_nx;

    always_comb begin
      sum_nx = sum_q;
      cy_nx  = cy_q;
      if (sclr) begin
        sum_nx = '0;
        cy_nx  = '0;
      end else if (ce) begin
        sum_nx = d_sum;
        cy_nx  = d_cy;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q <= '0;
        cy_q  <= '0;
      end else begin
        sum_q <= sum_nx;
        cy_q  <= cy_nx;
      end
    end

    assign q_sum = sum_q;
    assign q_cy  = cy_q;
  end else begin : g_comb
    assign q_sum = d_sum;
    assign q_cy  = d_cy;
  end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              sclr,
  input  logic [1:0]        mode_i,
  input  logic              sub_i,
  input  logic [HI_W-1:0]   opa_hi_i,
  input  logic [LO_W-1:0]   opa_lo_i,
  input  logic [WORD_W-1:0] opc_i,
  output logic [WORD_W-1:0] result_o,
  output logic [N_SLICE-1:0] carry_o
);
  lane_mode_e          mode;
  logic [WORD_W-1:0]   opnd;
  logic [N_SLICE-1:0]  lane_start, lane_end, cin, cout;
  logic [WORD_W-1:0]   sum_nx;
  logic [N_SLICE-1:0]  cy_nx;

  assign mode = lane_mode_e'(mode_i);
  assign opnd = {opa_hi_i, opa_lo_i};

  simd_lane_ctrl #(.N(N_SLICE)) u_ctrl (
    .mode_i  (mode),
    .start_o (lane_start),
    .end_o   (lane_end)
  );

  for (genvar k = 0; k < N_SLICE; k++) begin : g_slice
    // a lane start takes the op's own carry-in; otherwise ripple from below
    if (k == 0) begin : g_first
      assign cin[k] = sub_i;
    end else begin : g_next
      assign cin[k] = lane_start[k] ? sub_i : cout[k-1];
    end

    simd_slice #(.W(SLICE_W)) u_slice (
      .x_i    (opnd[k*SLICE_W +: SLICE_W]),
      .y_i    (opc_i[k*SLICE_W +: SLICE_W]),
      .sub_i  (sub_i),
      .cin_i  (cin[k]),
      .s_o    (sum_nx[k*SLICE_W +: SLICE_W]),
      .cout_o (cout[k])
    );

    assign cy_nx[k] = lane_end[k] & cout[k];
  end

  simd_out_stage #(.W(WORD_W), .CW(N_SLICE), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .sclr  (sclr),
    .d_sum (sum_nx),
    .d_cy  (cy_nx),
    .q_sum (result_o),
    .q_cy  (carry_o)
  );
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ce,
  input logic        sclr,
  input logic [1:0]  mode_i,
  input logic        sub_i,
  input logic [17:0] opa_lo_i,
  input logic [47:0] opc_i,
  input logic [47:0] sum_nx,
  input logic [3:0]  cy_nx,
  input logic [47:0] result_o,
  input logic [3:0]  carry_o
);
  logic [12:0] ref_add0, ref_sub0;
  assign ref_add0 = {1'b0, opa_lo_i[11:0]} + {1'b0, opc_i[11:0]};
  assign ref_sub0 = {1'b0, opc_i[11:0]} + {1'b0, ~opa_lo_i[11:0]} + 13'd1;

  // R7
  half_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01) |-> (cy_nx[0] == 1'b0 && cy_nx[2] == 1'b0));

  // R8
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 || mode_i == 2'b11) |-> (cy_nx[2:0] == 3'b000));

  // R3
  lane0_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && !sub_i) |-> (sum_nx[11:0] == ref_add0[11:0] && cy_nx[0] == ref_add0[12]));

  // R9
  lane0_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && sub_i) |-> (sum_nx[11:0] == ref_sub0[11:0] && cy_nx[0] == ref_sub0[12]));

  if (OUT_REG) begin : g_reg_chk
    // R10
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !sclr) |=> (result_o == $past(sum_nx) && carry_o == $past(cy_nx)));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce && !sclr) |=> ($stable(result_o) && $stable(carry_o)));

    // R12
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclr |=> (result_o == '0 && carry_o == '0));
  end else begin : g_comb_chk
    // R10
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (result_o == sum_nx && carry_o == cy_nx));
  end
endmodule

bind simd_addsub simd_addsub_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce       (ce),
  .sclr     (sclr),
  .mode_i   (mode_i),
  .sub_i    (sub_i),
  .opa_lo_i (opa_lo_i),
  .opc_i    (opc_i),
  .sum_nx   (sum_nx),
  .cy_nx    (cy_nx),
  .result_o (result_o),
  .carry_o  (carry_o)
);

// File: tb/simd_addsub_test.sv
`timescale 1ns/1ps
module simd_addsub_test;
  logic        clk = 1'b0;
  logic        rst_n, ce, sclr, sub_i;
  logic [1:0]  mode_i;
  logic [29:0] opa_hi_i;
  logic [17:0] opa_lo_i;
  logic [47:0] opc_i;
  logic [47:0] result_o;
  logic [3:0]  carry_o;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  simd_addsub #(.OUT_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr), .mode_i(mode_i),
    .sub_i(sub_i), .opa_hi_i(opa_hi_i), .opa_lo_i(opa_lo_i), .opc_i(opc_i),
    .result_o(result_o), .carry_o(carry_o)
  );

  // Lane-by-lane reference from the requirements
  function automatic void model(input logic [1:0] m, input logic s,
                                input logic [47:0] a, input logic [47:0] c,
                                output logic [47:0] r, output logic [3:0] cy);
    int lw, n;
    longint unsigned mask, xs, ys, t;
    lw = (m == 2'b10) ? 12 : (m == 2'b01) ? 24 : 48;
    n  = 48 / lw;
    mask = (64'd1 << lw) - 64'd1;
    r  = '0;
    cy = '0;
    for (int k = 0; k < n; k++) begin
      xs = (64'(a) >> (k * lw)) & mask;
      ys = (64'(c) >> (k * lw)) & mask;
      t  = s ? (ys + (~xs & mask) + 64'd1) : (xs + ys);
      r  = r | 48'((t & mask) << (k * lw));
      cy[(k + 1) * (lw / 12) - 1] = t[lw];
    end
  endfunction

  task automatic check(input string tag, input logic [47:0] er, input logic [3:0] ec);
    tests++;
    if (result_o !== er || carry_o !== ec) begin
      fails++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               tag, result_o, carry_o, er, ec);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b10:   return "R3 R6";
      2'b01:   return "R4 R7";
      default: return "R5 R8";
    endcase
  endfunction

  // Drive at negedge with ce=1, check at the following negedge
  task automatic apply(input string tag, input logic [1:0] m, input logic s,
                       input logic [29:0] hi, input logic [17:0] lo, input logic [47:0] c);
    logic [47:0] er;
    logic [3:0]  ec;
    @(negedge clk);
    mode_i = m; sub_i = s; opa_hi_i = hi; opa_lo_i = lo; opc_i = c;
    ce = 1'b1; sclr = 1'b0;
    model(m, s, {hi, lo}, c, er, ec);
    @(posedge clk);
    @(negedge clk);
    check({tag, " R10"}, er, ec);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [47:0] hold_r;
    logic [3:0]  hold_c;
    void'($urandom(32'd24681));
    rst_n = 1'b0; ce = 1'b0; sclr = 1'b0; sub_i = 1'b0; mode_i = 2'b00;
    opa_hi_i = '0; opa_lo_i = '0; opc_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 reset state", 48'h0, 4'h0);
    rst_n = 1'b1;

    // R1 single lane add, carry out of bit 47
    apply("R1 R8 full add wrap", 2'b00, 1'b0, 30'h3FFF_FFFF, 18'h3FFFF, 48'h1);
    apply("R1 full add", 2'b00, 1'b0, 30'h0123_4567, 18'h2_89AB, 48'h1111_2222_3333);
    // R5 mode code 11 behaves as single lane
    apply("R5 alt code full", 2'b11, 1'b0, 30'h3FFF_FFFF, 18'h3FFFF, 48'h1);
    // R3 all-ones + 1 per lane: no carry may cross
    apply("R3 R6 quarter cut", 2'b10, 1'b0, 30'h3FFF_FFFF, 18'h3FFFF, 48'h001_001_001_001);
    // R4 half lanes cut
    apply("R4 R7 half cut", 2'b01, 1'b0, 30'h3FFF_FFFF, 18'h3FFFF, 48'h000001_000001);
    // R2 R9 subtraction, equal operands: no borrow
    apply("R2 R9 sub equal", 2'b10, 1'b1, 30'h0ABC_DEF1, 18'h2_3456, 48'h2AF3_7BC6_3456);
    // R9 borrow in every lane
    apply("R9 sub borrow", 2'b10, 1'b1, 30'h0040_1004, 18'h0_1001, 48'h0);
    apply("R9 R7 half sub", 2'b01, 1'b1, 30'h0000_0400, 18'h0_0001, 48'h000002_000000);
    apply("R2 R8 full sub", 2'b00, 1'b1, 30'h0, 18'h0_0001, 48'h0);

    for (int i = 0; i < 300; i++) begin
      logic [1:0] m;
      logic s;
      m = 2'($urandom_range(0, 3));
      s = 1'($urandom());
      apply({mode_tag(m), s ? " R2 R9 random" : " R1 random"}, m, s,
            30'($urandom()), 18'($urandom()), {16'($urandom()), 32'($urandom())});
    end

    // R11 hold with ce=0 while inputs change
    apply("R11 preload", 2'b10, 1'b0, 30'h1234_5678, 18'h1_2345, 48'hFEDC_BA98_7654);
    hold_r = result_o; hold_c = carry_o;
    @(negedge clk);
    ce = 1'b0; opa_hi_i = 30'h3FFF_FFFF; opc_i = 48'hFFFF_FFFF_FFFF; sub_i = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R11 hold", hold_r, hold_c);
    @(posedge clk); @(negedge clk);
    check("R11 hold second edge", hold_r, hold_c);

    // R12 sync clear with ce=0
    sclr = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R12 sync clear", 48'h0, 4'h0);
    sclr = 1'b0;

    // R12 async reset mid-run
    apply("R12 preload", 2'b00, 1'b0, 30'h3FFF_FFFF, 18'h3FFFF, 48'h5);
    #1 rst_n = 1'b0;
    #0.5 check("R12 async reset", 48'h0, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;
    apply("R1 after reset", 2'b00, 1'b0, 30'h0, 18'h1, 48'h1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule